// File: doc/BRIEF.md
# Level-Grouped Scan Tree

This block is a full-scan structure fed from one serial scan input. Its flip-flops are sorted into levels, and every flip-flop in a level always receives the same shifted bit. The first level loads from the scan input. Each later level loads from one representative of the level before it. A test vector therefore needs only as many shift clocks as the tree has levels, not one clock per flip-flop. The scan-in data per vector equals the tree height in bits.

When scan enable is low, every flip-flop captures its own functional input. The captured response leaves through a bus of leaf outputs, one for each member of the widest level. Level membership is fixed when the block is built. There are two ways to describe it. A free map gives any flip-flop any level. A run mask keeps the chain order, so only neighbours can share a level. An optional cap on the output count splits any level that is too wide. The surplus flip-flops move to extra levels appended at the bottom of the tree.

Top module: `scan_tree`

## Requirements
- R1: While `rst` is high at a rising clock edge, every flip-flop is cleared to 0. This reset is synchronous and takes priority over `scan_en`.
- R2: With `scan_en` low, each flip-flop i loads `func_d[i]` at the clock edge, and `func_q[i]` shows it after that edge.
- R3: With `scan_en` high, every flip-flop on level 0 loads `scan_in` at each edge.
- R4: With `scan_en` high, every flip-flop on level k>0 loads the value held by the lowest-indexed member of level k-1. After n consecutive shifts, each flip-flop on a level k<n holds the bit applied k shifts before the latest one.
- R5: The height is the number of levels, and the levels in use must run without gaps from 0. After exactly height consecutive shifts, every flip-flop holds a bit from that burst, and the first bit applied sits in the deepest level.
- R6: `scan_out` is as wide as the largest level. Members of a level are ranked by increasing flip-flop index. `scan_out[j]` shows member j of the deepest level that has more than j members.
- R7: `scan_out[0]` shows the first bit of a burst exactly height shifts after that bit was applied.
- R8: With `MAX_OUT` smaller than a level, the member of rank r with r >= `MAX_OUT` moves to a new level and takes slot r mod `MAX_OUT` there. New levels come after all original levels, ordered by source level and then by chunk r / `MAX_OUT`.
- R9: With `MAP_MODE` = `MAP_RUNS`, the level of flip-flop i is the number of set bits of `RUN_STARTS` in positions 1 to i. Bit 0 is ignored.
- R10: In `MAP_FREE` mode, bits 8i+7:8i of `LEVEL_MAP` give the level of flip-flop i. After a capture, `scan_out` shows the captured values of the leaf flip-flops with no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 selects shift, 0 selects functional capture |
| scan_in | input | 1 | Serial test data into the tree root |
| func_d | input | NUM_FF | Functional data input per flip-flop |
| func_q | output | NUM_FF | State of each flip-flop |
| scan_out | output | OUT_W | Leaf outputs, width equal to the largest level |

## Verification
The bench builds three copies, all with nine flip-flops. The first uses a free map with five levels and a widest level of three. The second uses the same map with `MAX_OUT` set to 2, so one member is pushed to a sixth level and the bus narrows to two bits. The third uses the run mask with four levels in chain order. All three receive the same random shift bursts, including partial bursts, full bursts, bursts longer than each height and a reset in the middle of a burst. Because the heights differ, one stream exercises both the partly loaded and the fully loaded state of every copy, along with the leaf latency, the split placement and the run decoding.

// File: rtl/scan_tree_pkg.sv
`timescale 1ns/1ps
package scan_tree_pkg;

    localparam int MAX_FF = 64;
    localparam int LVL_W  = 8;

    typedef enum logic {MAP_FREE = 1'b0, MAP_RUNS = 1'b1} map_mode_e;

    typedef logic [MAX_FF*LVL_W-1:0] lvl_map_t;
    typedef logic [MAX_FF-1:0]       run_mask_t;

    typedef struct packed {
        map_mode_e mode;
        lvl_map_t  map;
        run_mask_t starts;
        int        n;
        int        maxo;
    } tree_cfg_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [LVL_W-1:0] slot;
    } tree_loc_t;

    typedef struct packed {
        logic scan_d;
        logic func_d;
    } cell_in_t;

    // level before any output-limit split
    function automatic int raw_level(tree_cfg_t c, int i);
        int lv = 0;
        if (c.mode == MAP_FREE) begin
            lv = int'(c.map[i*LVL_W +: LVL_W]);
        end else begin
            for (int k = 1; k <= i; k++) if (c.starts[k]) lv++;
        end
        return lv;
    endfunction

    function automatic int raw_groups(tree_cfg_t c);
        int g = 0;
        for (int i = 0; i < c.n; i++) if (raw_level(c, i) + 1 > g) g = raw_level(c, i) + 1;
        return g;
    endfunction

    function automatic int raw_size(tree_cfg_t c, int g);
        int s = 0;
        for (int i = 0; i < c.n; i++) if (raw_level(c, i) == g) s++;
        return s;
    endfunction

    // extra levels created by splitting groups below g_lim
    function automatic int spill_levels(tree_cfg_t c, int g_lim);
        int s = 0;
        for (int g = 0; g < g_lim; g++)
            if (raw_size(c, g) > c.maxo) s += (raw_size(c, g) + c.maxo - 1) / c.maxo - 1;
        return s;
    endfunction

    function automatic int tree_height(tree_cfg_t c);
        return raw_groups(c) + spill_levels(c, raw_groups(c));
    endfunction

    function automatic tree_loc_t locate(tree_cfg_t c, int i);
        tree_loc_t loc;
        int raw   = raw_level(c, i);
        int rank  = 0;
        int chunk;
        int lv;
        for (int j = 0; j < i; j++) if (raw_level(c, j) == raw) rank++;
        chunk = rank / c.maxo;
        lv = (chunk == 0) ? raw : raw_groups(c) + spill_levels(c, raw) + chunk - 1;
        loc.level = LVL_W'(lv);
        loc.slot  = LVL_W'(rank % c.maxo);
        return loc;
    endfunction

    function automatic int level_size(tree_cfg_t c, int lvl);
        int s = 0;
        tree_loc_t loc;
        for (int i = 0; i < c.n; i++) begin
            loc = locate(c, i);
            if (int'(loc.level) == lvl) s++;
        end
        return s;
    endfunction

    function automatic int member_at(tree_cfg_t c, int lvl, int slot);
        int r = 0;
        tree_loc_t loc;
        for (int i = 0; i < c.n; i++) begin
            loc = locate(c, i);
            if (int'(loc.level) == lvl && int'(loc.slot) == slot) r = i;
        end
        return r;
    endfunction

    function automatic int out_width(tree_cfg_t c);
        int w = 1;
        for (int l = 0; l < tree_height(c); l++) if (level_size(c, l) > w) w = level_size(c, l);
        return w;
    endfunction

    function automatic int leaf_of(tree_cfg_t c, int j);
        int r = 0;
        for (int l = 0; l < tree_height(c); l++) if (level_size(c, l) > j) r = member_at(c, l, j);
        return r;
    endfunction

    // shift source of flip-flop i, -1 means the scan input
    function automatic int src_of(tree_cfg_t c, int i);
        tree_loc_t loc = locate(c, i);
        if (loc.level == '0) return -1;
        return member_at(c, int'(loc.level) - 1, 0);
    endfunction

endpackage

// File: rtl/scan_tree_cell.sv
`timescale 1ns/1ps
module scan_tree_cell
    import scan_tree_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scan_en,
    input  cell_in_t din,
    output logic     q
);

    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (scan_en) q <= din.scan_d;
        else              q <= din.func_d;
    end

endmodule

// File: rtl/scan_tree_route.sv
`timescale 1ns/1ps
module scan_tree_route
    import scan_tree_pkg::*;
#(
    parameter int        NUM_FF     = 9,
    parameter map_mode_e MAP_MODE   = MAP_FREE,
    parameter lvl_map_t  LEVEL_MAP  = {440'd0, 8'd0, 8'd4, 8'd1, 8'd2, 8'd3, 8'd2, 8'd2, 8'd1, 8'd0},
    parameter run_mask_t RUN_STARTS = '0,
    parameter int        MAX_OUT    = NUM_FF,
    localparam tree_cfg_t CFG = '{mode: MAP_MODE, map: LEVEL_MAP, starts: RUN_STARTS,
                                  n: NUM_FF, maxo: MAX_OUT},
    localparam int       OUT_W      = out_width(CFG)
) (
    input  logic              scan_in,
    input  logic [NUM_FF-1:0] state_q,
    output logic [NUM_FF-1:0] shift_src,
    output logic [NUM_FF-1:0] func_q,
    output logic [OUT_W-1:0]  scan_out
);

    assign func_q = state_q;

    for (genvar i = 0; i < NUM_FF; i++) begin : g_src
        localparam int SRC = src_of(CFG, i);
        if (SRC < 0) begin : g_root
            assign shift_src[i] = scan_in;
        end else begin : g_inner
            assign shift_src[i] = state_q[SRC];
        end
    end

    for (genvar j = 0; j < OUT_W; j++) begin : g_leaf
        localparam int LEAF = leaf_of(CFG, j);
        assign scan_out[j] = state_q[LEAF];
    end

endmodule

// File: rtl/scan_tree.sv
`timescale 1ns/1ps
module scan_tree
    import scan_tree_pkg::*;
#(
    parameter int        NUM_FF     = 9,
    parameter map_mode_e MAP_MODE   = MAP_FREE,
    parameter lvl_map_t  LEVEL_MAP  = {440'd0, 8'd0, 8'd4, 8'd1, 8'd2, 8'd3, 8'd2, 8'd2, 8'd1, 8'd0},
    parameter run_mask_t RUN_STARTS = '0,
    parameter int        MAX_OUT    = NUM_FF,
    localparam tree_cfg_t CFG = '{mode: MAP_MODE, map: LEVEL_MAP, starts: RUN_STARTS,
                                  n: NUM_FF, maxo: MAX_OUT},
    localparam int       OUT_W      = out_width(CFG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              scan_in,
    input  logic [NUM_FF-1:0] func_d,
    output logic [NUM_FF-1:0] func_q,
    output logic [OUT_W-1:0]  scan_out
);

    logic [NUM_FF-1:0] state_q;
    logic [NUM_FF-1:0] shift_src;
    cell_in_t          cell_in [NUM_FF];

    for (genvar i = 0; i < NUM_FF; i++) begin : g_cell
        assign cell_in[i] = '{scan_d: shift_src[i], func_d: func_d[i]};
        scan_tree_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .scan_en (scan_en),
            .din     (cell_in[i]),
            .q       (state_q[i])
        );
    end

    scan_tree_route #(
        .NUM_FF     (NUM_FF),
        .MAP_MODE   (MAP_MODE),
        .LEVEL_MAP  (LEVEL_MAP),
        .RUN_STARTS (RUN_STARTS),
        .MAX_OUT    (MAX_OUT)
    ) u_route (
        .scan_in   (scan_in),
        .state_q   (state_q),
        .shift_src (shift_src),
        .func_q    (func_q),
        .scan_out  (scan_out)
    );

endmodule

// File: rtl/scan_tree_chk.sv
`timescale 1ns/1ps
module scan_tree_chk
    import scan_tree_pkg::*;
#(
    parameter int        NUM_FF     = 9,
    parameter map_mode_e MAP_MODE   = MAP_FREE,
    parameter lvl_map_t  LEVEL_MAP  = {440'd0, 8'd0, 8'd4, 8'd1, 8'd2, 8'd3, 8'd2, 8'd2, 8'd1, 8'd0},
    parameter run_mask_t RUN_STARTS = '0,
    parameter int        MAX_OUT    = NUM_FF,
    localparam tree_cfg_t CFG = '{mode: MAP_MODE, map: LEVEL_MAP, starts: RUN_STARTS,
                                  n: NUM_FF, maxo: MAX_OUT},
    localparam int       OUT_W      = out_width(CFG)
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_en,
    input logic              scan_in,
    input logic [NUM_FF-1:0] func_d,
    input logic [NUM_FF-1:0] func_q,
    input logic [OUT_W-1:0]  scan_out
);

    for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
        localparam int SRC = src_of(CFG, i);

        p_capture_r2: assert property (@(posedge clk) disable iff (rst)
            (!$past(scan_en) && !$past(rst)) |-> func_q[i] == $past(func_d[i]))
            else $error("capture mismatch on flip-flop %0d", i);

        if (SRC < 0) begin : g_root
            p_root_load_r3: assert property (@(posedge clk) disable iff (rst)
                ($past(scan_en) && !$past(rst)) |-> func_q[i] == $past(scan_in))
                else $error("root level did not load scan input, flip-flop %0d", i);
        end else begin : g_inner
            p_level_step_r4: assert property (@(posedge clk) disable iff (rst)
                ($past(scan_en) && !$past(rst)) |-> func_q[i] == $past(func_q[SRC]))
                else $error("level step broken at flip-flop %0d", i);
        end
    end

    for (genvar j = 0; j < OUT_W; j++) begin : g_out
        localparam int LEAF = leaf_of(CFG, j);
        localparam int LSRC = src_of(CFG, LEAF);
        if (LSRC < 0) begin : g_root
            p_leaf_out_r6: assert property (@(posedge clk) disable iff (rst)
                ($past(scan_en) && !$past(rst)) |-> scan_out[j] == $past(scan_in))
                else $error("leaf output %0d wrong", j);
        end else begin : g_inner
            p_leaf_out_r6: assert property (@(posedge clk) disable iff (rst)
                ($past(scan_en) && !$past(rst)) |-> scan_out[j] == $past(func_q[LSRC]))
                else $error("leaf output %0d wrong", j);
        end
    end

endmodule

bind scan_tree scan_tree_chk #(
    .NUM_FF     (NUM_FF),
    .MAP_MODE   (MAP_MODE),
    .LEVEL_MAP  (LEVEL_MAP),
    .RUN_STARTS (RUN_STARTS),
    .MAX_OUT    (MAX_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .func_d   (func_d),
    .func_q   (func_q),
    .scan_out (scan_out)
);

// File: tb/scan_tree_tb.sv
`timescale 1ns/1ps
module scan_tree_tb;
    import scan_tree_pkg::*;

    logic       clk     = 1'b0;
    logic       rst     = 1'b1;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [8:0] func_d  = '1;
    logic [8:0] q0, q1, q2;
    logic [2:0] so0, so2;
    logic [1:0] so1;

    int edges    = 0;
    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) edges <= edges + 1;

    scan_tree u_dut (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .func_q(q0), .scan_out(so0));

    scan_tree #(.MAX_OUT(2)) u_dut_lim (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .func_q(q1), .scan_out(so1));

    scan_tree #(.MAP_MODE(MAP_RUNS), .RUN_STARTS(64'h65)) u_dut_adj (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .func_q(q2), .scan_out(so2));

    // expected structure, derived by hand from R5, R6, R8 and R9
    int    lv   [3][9] = '{'{0,1,2,2,3,2,1,4,0}, '{0,1,2,2,3,5,1,4,0}, '{0,0,1,1,1,2,3,3,3}};
    int    hgt  [3]    = '{5, 6, 4};
    int    leaf [3][3] = '{'{7,3,5}, '{5,3,-1}, '{6,7,8}};
    string rq   [3]    = '{"R4", "R8", "R9"};

    typedef struct {
        int         due;
        int         dut;
        bit         is_out;
        logic [8:0] exp;
        logic [8:0] mask;
        string      req;
    } item_t;

    item_t sb[$];
    logic  hist[$];

    function automatic logic [8:0] pick(int d, bit is_out);
        case (d)
            0:       return is_out ? {6'b0, so0} : q0;
            1:       return is_out ? {7'b0, so1} : q1;
            default: return is_out ? {6'b0, so2} : q2;
        endcase
    endfunction

    // monitor: compare every item that falls due on this cycle
    always @(negedge clk) begin
        for (int k = sb.size() - 1; k >= 0; k--) begin
            if (sb[k].due == edges) begin
                logic [8:0] act;
                act = pick(sb[k].dut, sb[k].is_out);
                n_checks++;
                if ((act & sb[k].mask) !== (sb[k].exp & sb[k].mask)) begin
                    n_fail++;
                    $display("FAIL %s dut%0d %s actual=%h expected=%h", sb[k].req, sb[k].dut,
                             sb[k].is_out ? "scan_out" : "func_q",
                             act & sb[k].mask, sb[k].exp & sb[k].mask);
                end
                sb.delete(k);
            end
        end
    end

    task automatic push(int d, bit is_out, logic [8:0] e, logic [8:0] m, string r);
        item_t it;
        it.due = edges + 1; it.dut = d; it.is_out = is_out;
        it.exp = e; it.mask = m; it.req = r;
        sb.push_back(it);
    endtask

    task automatic expect_zero(string r);
        for (int d = 0; d < 3; d++) begin
            push(d, 1'b0, 9'h000, 9'h1FF, r);
            push(d, 1'b1, 9'h000, 9'h1FF, r);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scan_en = 1'b1; scan_in = 1'b1;
        hist.delete();
        expect_zero("R1");
    endtask

    task automatic capture(logic [8:0] p);
        @(negedge clk);
        rst = 1'b0; scan_en = 1'b0; func_d = p;
        hist.delete();
        for (int d = 0; d < 3; d++) begin
            logic [8:0] e = '0;
            logic [8:0] m = '0;
            push(d, 1'b0, p, 9'h1FF, "R2");
            for (int j = 0; j < 3; j++)
                if (leaf[d][j] >= 0) begin e[j] = p[leaf[d][j]]; m[j] = 1'b1; end
            push(d, 1'b1, e, m, "R10");
        end
    endtask

    task automatic shift_one(logic b);
        int n;
        @(negedge clk);
        rst = 1'b0; scan_en = 1'b1; scan_in = b;
        hist.push_back(b);
        n = hist.size();
        for (int d = 0; d < 3; d++) begin
            logic [8:0] e = '0;
            logic [8:0] m = '0;
            logic [8:0] eo = '0;
            logic [8:0] mo = '0;
            for (int i = 0; i < 9; i++)
                if (n - 1 - lv[d][i] >= 0) begin e[i] = hist[n-1-lv[d][i]]; m[i] = 1'b1; end
            push(d, 1'b0, e, m, (n == hgt[d]) ? "R5" : ((n == 1) ? "R3" : rq[d]));
            for (int j = 0; j < 3; j++)
                if (leaf[d][j] >= 0 && n - 1 - lv[d][leaf[d][j]] >= 0) begin
                    eo[j] = hist[n-1-lv[d][leaf[d][j]]]; mo[j] = 1'b1;
                end
            push(d, 1'b1, eo, mo, (j0_due(n, d)) ? "R7" : "R6");
        end
    endtask

    function automatic bit j0_due(int n, int d);
        return n == hgt[d];
    endfunction

    task automatic shift_burst(int len);
        for (int k = 0; k < len; k++) shift_one(1'($urandom));
    endtask

    task automatic shift_pattern(logic [15:0] pat, int len);
        for (int k = 0; k < len; k++) shift_one(pat[k]);
    endtask

    initial begin
        @(negedge clk);
        expect_zero("R1");                 // reset held with functional data all ones
        @(negedge clk);
        capture(9'h1A5);
        capture(9'h05A);
        shift_burst(8);                    // longer than every height
        capture(9'h1FF);
        shift_burst(3);                    // partial burst
        capture(9'h000);
        shift_pattern(16'h5555, 7);
        shift_pattern(16'h00F0, 6);
        do_reset();                        // reset in the middle of a burst
        shift_burst(4);                    // exactly the height of the run-mapped copy
        capture(9'h0C3);
        shift_burst(5);                    // exactly the height of the free-mapped copy
        capture(9'h13C);
        shift_burst(6);                    // exactly the height of the split copy
        for (int r = 0; r < 4; r++) begin
            capture(9'($urandom));
            shift_burst(2 + r * 2);
        end
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R6 pending=%0d expected=0", sb.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog req=none actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule